// File: doc/BRIEF.md
# Buffered Serial Transmitter with Completion Flag

This block serialises bytes onto an asynchronous line. One holding register sits in front of a shift register. Software writes a byte into the holding register whenever the buffer-empty flag is high. The shift register takes that byte at the next bit boundary and sends it as a frame. A frame has a start bit, 5 to 8 data bits, an optional parity bit and one or two stop bits. A baud tick input paces the line, and each bit lasts sixteen ticks.

The done flag tells half-duplex software when the line can be released. It rises only when the last frame has fully left the shift register and nothing waits in the holding register. It clears on an interrupt acknowledge or on an explicit write of a one.

Clearing the enable does not stop the transmitter at once. Queued data is sent first, and only then does the block drop its pin output-enable.

Top module: `sertx_unit`

## Requirements
- R1: A control write (`ctrl_wr`) loads `ctrl_wdata`, whose bits have these meanings:
  - bit 0: enable.
  - bit 1: buffer-empty interrupt enable.
  - bit 2: done interrupt enable.
  - bit 3: odd parity when 1, even parity when 0.
  - bit 4: parity on.
  - bit 5: two stop bits.
  - bits 7:6: data length code, where the length is 5 plus the code.
- R2: A frame has these parts, in order:
  - a low start bit;
  - the data bits, least significant first;
  - the high stop bits.

  Each bit lasts 16 baud ticks, and the line is high when no frame is being sent.
- R3: With parity on, a parity bit sits between the last data bit and the first stop bit. It is the XOR of the data bits, inverted when odd parity is selected.
- R4: `buf_empty` is high whenever the holding register can take a byte. A data write while it is low is ignored. `irq_empty` equals `buf_empty` AND control bit 1.
- R5: When a frame ends and the holding register is full, the next start bit follows the last stop bit directly, with no idle bit.
- R6: A frame starts only while the transmitter is active. Data written while disabled is held and not sent.
- R7: `tx_done` sets only when the shift register has finished its frame and the holding register is empty.
- R8: `tx_done` clears on `done_ack`. It also clears on `clr_wr` with `clr_bit` at 1. `clr_wr` with `clr_bit` at 0 leaves it unchanged.
- R9: `irq_done` equals `tx_done` AND control bit 2.
- R10: After the enable bit is cleared, every queued byte is still sent, and `txd_oe` stays high until the last one has finished.
- R11: Once disabled, `txd_oe` is low and `txd` rests high.
- R12: After reset, the outputs take these values:

  | Output | Reset value |
  |---|---|
  | `txd` | high |
  | `txd_oe` | low |
  | `buf_empty` | high |
  | `tx_done` | low |
  | `irq_empty` | low |
  | `irq_done` | low |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_data_en | input | 1 | Data write strobe |
| wr_data | input | 8 | Byte to transmit |
| ctrl_wr | input | 1 | Control write strobe |
| ctrl_wdata | input | 8 | Control byte (layout in R1) |
| clr_wr | input | 1 | Flag clear write strobe |
| clr_bit | input | 1 | Value written to the done flag position |
| done_ack | input | 1 | Done interrupt acknowledge |
| baud_tick | input | 1 | Baud tick, 16 per bit |
| txd | output | 1 | Serial line |
| txd_oe | output | 1 | Pin output-enable |
| buf_empty | output | 1 | Holding register free |
| tx_done | output | 1 | Transmit complete flag |
| irq_empty | output | 1 | Buffer-empty interrupt request |
| irq_done | output | 1 | Done interrupt request |

## Verification
The bench targets four corner cases.
- **Back-to-back frames.** It times consecutive start edges. A design that inserted an idle bit between buffered frames would stretch that gap by a full bit.
- **Done flag timing.** It watches the done flag across a pair of queued frames. A design that raised the flag at the end of the first frame, while the second still sat in the buffer, would flag completion early.
- **Write while full and write-zero clear.** It writes a byte while the buffer is full, and clears the flag with a zero. A design that accepted the extra byte would send an extra frame. A design that treated a zero write as a clear would drop the flag.
- **Disable during transfer.** It clears the enable with two bytes still queued. A design that disabled at once would truncate the traffic or release the pin mid-frame. A design that lost the disable would transmit data written afterwards.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  localparam int unsigned LEN_W = 2;

  // Control byte; the first member is the most significant field.
  typedef struct packed {
    logic [LEN_W-1:0] len_code;  // [7:6]
    logic             stop_two;  // [5]
    logic             par_on;    // [4]
    logic             par_odd;   // [3]
    logic             ie_done;   // [2]
    logic             ie_empty;  // [1]
    logic             tx_on;     // [0]
  } sertx_ctrl_t;

  localparam int unsigned CTRL_W = $bits(sertx_ctrl_t);
endpackage

// File: rtl/sertx_bitclk.sv
module sertx_bitclk #(
  parameter int unsigned TICKS_PER_BIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic baud_tick,
  output logic bit_stb
);
  localparam int unsigned CW = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_BIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      bit_stb <= 1'b0;
    end else begin
      bit_stb <= 1'b0;
      if (baud_tick) begin
        if (cnt == LAST) begin
          cnt     <= '0;
          bit_stb <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R2: a bit boundary is a single-cycle event
  p_stb_single_r2: assert property (@(posedge clk) disable iff (rst)
    bit_stb |=> !bit_stb);
endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned LEN_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_stb,
  input  logic              load_ok,
  input  logic [DATA_W-1:0] ld_data,
  input  logic [LEN_W-1:0]  len_code,
  input  logic              par_on,
  input  logic              par_odd,
  input  logic              stop_two,
  output logic              busy,
  output logic              txd,
  output logic              take,
  output logic              frame_end
);
  localparam int unsigned MIN_LEN = DATA_W - (2 ** LEN_W) + 1;
  localparam int unsigned FRAME_W = DATA_W + 3;        // data, parity, two stops
  localparam int unsigned RW      = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] shreg;
  logic [FRAME_W-1:0] vec;
  logic [RW-1:0]      remain;
  logic [RW-1:0]      nleft;
  logic               last;
  logic               par_bit;
  logic [DATA_W-1:0]  masked;
  int unsigned        nbits;

  always_comb begin
    nbits = MIN_LEN + int'(len_code);
    for (int i = 0; i < DATA_W; i++) masked[i] = (i < nbits) ? ld_data[i] : 1'b0;
    par_bit = (^masked) ^ par_odd;
    vec = '1;
    for (int j = 0; j < FRAME_W; j++) begin
      if (j < DATA_W && j < nbits) vec[j] = ld_data[j];
      else if (j == nbits && par_on) vec[j] = par_bit;
    end
    nleft = RW'(nbits) + RW'(par_on) + RW'(1) + RW'(stop_two);
  end

  assign last      = busy && (remain == '0);
  assign take      = bit_stb && load_ok && (!busy || last);
  assign frame_end = bit_stb && last && !load_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      txd    <= 1'b1;
      shreg  <= '1;
      remain <= '0;
    end else if (take) begin
      busy   <= 1'b1;
      txd    <= 1'b0;
      shreg  <= vec;
      remain <= nleft;
    end else if (frame_end) begin
      busy <= 1'b0;
      txd  <= 1'b1;
    end else if (bit_stb && busy) begin
      txd    <= shreg[0];
      shreg  <= {1'b1, shreg[FRAME_W-1:1]};
      remain <= remain - 1'b1;
    end
  end

  // R2: the line rests high between frames
  p_idle_high_r2: assert property (@(posedge clk) disable iff (rst)
    !busy |-> txd);
  // R2: a taken byte begins with a low start bit
  p_start_low_r2: assert property (@(posedge clk) disable iff (rst)
    take |=> (busy && !txd));
  // R5: a finished frame with no data waiting leaves the shifter idle
  p_end_idle_r5: assert property (@(posedge clk) disable iff (rst)
    frame_end |=> !busy);
endmodule

// File: rtl/sertx_unit.sv
module sertx_unit
  import sertx_pkg::*;
#(
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned TICKS_PER_BIT = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_data_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ctrl_wr,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  input  logic              clr_wr,
  input  logic              clr_bit,
  input  logic              done_ack,
  input  logic              baud_tick,
  output logic              txd,
  output logic              txd_oe,
  output logic              buf_empty,
  output logic              tx_done,
  output logic              irq_empty,
  output logic              irq_done
);
  sertx_ctrl_t       ctrl_q;
  logic [DATA_W-1:0] buf_q;
  logic              buf_full;
  logic              tx_active;
  logic              bit_stb;
  logic              busy;
  logic              take;
  logic              frame_end;
  logic              wr_accept;

  assign wr_accept = wr_data_en && !buf_full;

  sertx_bitclk #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_bitclk (
    .clk(clk), .rst(rst), .baud_tick(baud_tick), .bit_stb(bit_stb)
  );

  sertx_shifter #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_shift (
    .clk(clk), .rst(rst), .bit_stb(bit_stb),
    .load_ok(buf_full && tx_active), .ld_data(buf_q),
    .len_code(ctrl_q.len_code), .par_on(ctrl_q.par_on),
    .par_odd(ctrl_q.par_odd), .stop_two(ctrl_q.stop_two),
    .busy(busy), .txd(txd), .take(take), .frame_end(frame_end)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      buf_q     <= '0;
      buf_full  <= 1'b0;
      tx_active <= 1'b0;
      tx_done   <= 1'b0;
    end else begin
      if (ctrl_wr) ctrl_q <= sertx_ctrl_t'(ctrl_wdata);

      if (take) begin
        buf_full <= 1'b0;
      end else if (wr_accept) begin
        buf_full <= 1'b1;
        buf_q    <= wr_data;
      end

      if (ctrl_q.tx_on)               tx_active <= 1'b1;
      else if (!busy && !buf_full)    tx_active <= 1'b0;

      if (frame_end && !wr_accept)                tx_done <= 1'b1;
      else if (done_ack || (clr_wr && clr_bit))   tx_done <= 1'b0;
    end
  end

  assign txd_oe    = tx_active;
  assign buf_empty = !buf_full;
  assign irq_empty = buf_empty && ctrl_q.ie_empty;
  assign irq_done  = tx_done && ctrl_q.ie_done;

  // R7: completion only with nothing in flight or waiting
  p_done_clean_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_done) |-> (!busy && !buf_full));
  // R8: acknowledge clears the flag
  p_ack_clears_r8: assert property (@(posedge clk) disable iff (rst)
    (done_ack && !frame_end) |=> !tx_done);
  // R8: writing a zero keeps the flag
  p_zero_keeps_r8: assert property (@(posedge clk) disable iff (rst)
    (clr_wr && !clr_bit && !done_ack && tx_done) |=> tx_done);
  // R4: a write into a full holding register changes nothing
  p_full_ignore_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_data_en && buf_full && !take) |=> (buf_full && $stable(buf_q)));
  // R9: done request implies done flag
  p_irq_done_r9: assert property (@(posedge clk) disable iff (rst)
    irq_done |-> tx_done);
  // R10: the pin is released only after draining
  p_oe_release_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(txd_oe) |-> (!busy && !buf_full && !ctrl_q.tx_on));
  // R11: a released pin carries an idle level
  p_oe_idle_r11: assert property (@(posedge clk) disable iff (rst)
    !txd_oe |-> txd);
  // R6: no frame runs while inactive
  p_no_run_off_r6: assert property (@(posedge clk) disable iff (rst)
    !tx_active |-> !busy);
endmodule

// File: tb/sim_sertx_unit.sv
`timescale 1ns/1ps
module sim_sertx_unit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_data_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic ctrl_wr = 1'b0;
  logic [7:0] ctrl_wdata = '0;
  logic clr_wr = 1'b0, clr_bit = 1'b0, done_ack = 1'b0, baud_tick = 1'b0;
  logic txd, txd_oe, buf_empty, tx_done, irq_empty, irq_done;

  sertx_unit u0 (
    .clk(clk), .rst(rst), .wr_data_en(wr_data_en), .wr_data(wr_data),
    .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata), .clr_wr(clr_wr),
    .clr_bit(clr_bit), .done_ack(done_ack), .baud_tick(baud_tick),
    .txd(txd), .txd_oe(txd_oe), .buf_empty(buf_empty), .tx_done(tx_done),
    .irq_empty(irq_empty), .irq_done(irq_done)
  );

  always #2.5 clk = ~clk;
  always @(negedge clk) baud_tick <= ~baud_tick;   // one tick per 2 clocks -> 32 clocks per bit

  typedef struct { logic [7:0] d; int n; bit pe; bit odd; bit two; } item_t;
  item_t sb[$];
  int starts[$];
  int n_chk = 0, n_bad = 0, frames_done = 0, cyc = 0;
  int cur_n = 5; bit cur_pe = 0, cur_odd = 0, cur_two = 0;
  logic [11:0] m_exp, m_got;
  int m_nb;
  bit m_oe;
  item_t m_it;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic setctl(input logic [7:0] v);
    ctrl_wr = 1'b1; ctrl_wdata = v;
    cur_n = 5 + int'(v[7:6]); cur_two = v[5]; cur_pe = v[4]; cur_odd = v[3];
    @(negedge clk);
    ctrl_wr = 1'b0;
  endtask

  task automatic poke(input logic [7:0] d);
    wr_data_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_data_en = 1'b0;
  endtask

  // driver: queue the expected frame, then write the byte
  task automatic send(input logic [7:0] d);
    item_t it;
    for (int g = 0; g < 5000 && !buf_empty; g++) @(negedge clk);
    it.d = d; it.n = cur_n; it.pe = cur_pe; it.odd = cur_odd; it.two = cur_two;
    sb.push_back(it);
    poke(d);
  endtask

  task automatic wait_done(input int exp_frames, input bit exp_irq);
    for (int g = 0; g < 20000 && !tx_done; g++) @(negedge clk);
    chk(tx_done && frames_done == exp_frames, "R7 done after last frame", frames_done, exp_frames);
    chk(irq_done == exp_irq, "R9 done request", irq_done, exp_irq);
  endtask

  // monitor: detect start, sample bit centres, compare with the scoreboard
  initial begin
    @(negedge clk);
    while (rst) @(negedge clk);
    forever begin
      @(negedge clk);
      if (txd === 1'b0) begin
        starts.push_back(cyc);
        repeat (16) @(negedge clk);
        if (sb.size() == 0) begin
          chk(1'b0, "R4 R6 unexpected frame", 1, 0);
          while (txd !== 1'b1) @(negedge clk);
        end else begin
          m_it = sb.pop_front();
          m_exp = '1; m_exp[0] = 1'b0;
          for (int i = 0; i < m_it.n; i++) m_exp[1+i] = m_it.d[i];
          m_nb = 1 + m_it.n;
          if (m_it.pe) begin
            logic p;
            p = m_it.odd;
            for (int i = 0; i < m_it.n; i++) p = p ^ m_it.d[i];
            m_exp[m_nb] = p;
            m_nb++;
          end
          m_nb = m_nb + (m_it.two ? 2 : 1);
          m_got = '1; m_got[0] = txd; m_oe = txd_oe;
          for (int k = 1; k < m_nb; k++) begin
            repeat (32) @(negedge clk);
            m_got[k] = txd; m_oe = m_oe & txd_oe;
          end
          chk(m_got == m_exp, "R2 R3 frame bits", m_got, m_exp);
          chk(m_oe, "R10 pin driven during frame", m_oe, 1);
          frames_done++;
        end
      end
    end
  end

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R2 watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    chk(txd && !txd_oe && buf_empty && !tx_done && !irq_empty && !irq_done,
        "R12 reset outputs", {txd, txd_oe, buf_empty, tx_done, irq_empty, irq_done}, 6'b101000);

    // 8 data, no parity, 1 stop; enable with both interrupt enables (R1)
    setctl(8'b1100_0111);
    repeat (2) @(negedge clk);
    chk(txd_oe, "R11 pin driven when enabled", txd_oe, 1);
    chk(irq_empty, "R4 empty request", irq_empty, 1);
    send(8'hA5);
    chk(!buf_empty && !irq_empty, "R4 full after write", {buf_empty, irq_empty}, 0);
    wait_done(1, 1'b1);
    clr_wr = 1'b1; clr_bit = 1'b0; @(negedge clk); clr_wr = 1'b0;
    chk(tx_done, "R8 zero write keeps flag", tx_done, 1);
    clr_wr = 1'b1; clr_bit = 1'b1; @(negedge clk); clr_wr = 1'b0; clr_bit = 1'b0;
    chk(!tx_done, "R8 one write clears flag", tx_done, 0);

    // 5 data, even parity, back-to-back frames
    setctl(8'b0001_0111);
    send(8'h13);
    send(8'h1E);
    wait_done(3, 1'b1);
    chk(starts[2] - starts[1] == 8 * 32, "R5 no idle between frames", starts[2] - starts[1], 8 * 32);
    done_ack = 1'b1; @(negedge clk); done_ack = 1'b0;
    chk(!tx_done, "R8 ack clears flag", tx_done, 0);

    // 7 data, odd parity, 2 stops; done interrupt off
    setctl(8'b1011_1011);
    send(8'h5A);
    send(8'h7F);
    wait_done(5, 1'b0);
    done_ack = 1'b1; @(negedge clk); done_ack = 1'b0;

    // 6 data, no parity: write into a full buffer is dropped
    setctl(8'b0100_0111);
    send(8'h2C);
    send(8'h15);
    poke(8'h3F);
    chk(!buf_empty, "R4 buffer still full", buf_empty, 0);
    wait_done(7, 1'b1);
    done_ack = 1'b1; @(negedge clk); done_ack = 1'b0;

    // disable with data queued
    setctl(8'b1100_0111);
    send(8'h11);
    send(8'h22);
    setctl(8'b1100_0110);
    chk(txd_oe, "R10 pin held while draining", txd_oe, 1);
    wait_done(9, 1'b1);
    repeat (3) @(negedge clk);
    chk(!txd_oe && txd, "R11 released after drain", {txd_oe, txd}, 2'b01);
    poke(8'h33);
    repeat (1500) @(negedge clk);
    chk(frames_done == 9 && !buf_empty, "R6 no frame while disabled", frames_done, 9);
    chk(!txd_oe && txd, "R11 pin stays released", {txd_oe, txd}, 2'b01);
    chk(sb.size() == 0, "R2 all frames delivered", sb.size(), 0);
    summary();
    $finish;
  end
endmodule